// File: doc/BRIEF.md
# Quadrature Pulse Counter Core

This block counts pulses on two input lines, S0 and S1. It can run in one of three counting modes. Two of them treat S0 as a single clock-like input, where one chosen edge is one event and the direction comes from S1 or from a configuration bit. The third decodes S0/S1 as a quadrature pair from a shaft encoder, so that each legal Gray-code step is one event up or down. A fourth setting, disabled, stops all counting.

The decoded events feed two counters, a main counter and an auxiliary counter. Each counter passes the events through its own four-way filter. The main counter wraps at a programmable top value and raises overflow and underflow flags. The top value is written into a buffer and copied into the active register after a fixed delay. A third flag marks a reversal in the direction of the events.

Software uses the block through a single-cycle write port and a registered read port. Flags can be set, cleared and masked by software, and their masked OR drives a registered interrupt line. The inputs are brought into the clock domain through a synchronizer chain. Pin routing and the selection of input sources sit outside the block.

Top module: `qpc_core`

## Requirements
- R1: After reset the registers hold these values: configuration (address 0) = 0x0034, which is mode disabled, main filter up-only and auxiliary filter none. Both counters = 0. Top (address 4) and top buffer (address 3) = all ones. Flags (address 5) = 0, enable mask (address 7) = 0, and irq = 0.
- R2: In mode 0 (disabled), edges on S0/S1 change neither counter.
- R3: The mode sits in configuration bits [1:0]. In modes 1 and 2 (single input), each rising edge of S0 is one event, or each falling edge when bit 6 = 1. The event counts down when its direction source is 1, and otherwise counts up. The direction source is S1 when bit 7 = 1 and bit 8 when bit 7 = 0. A change on an input pin shows in the counter two clock edges after the first edge that samples it.
- R4: In mode 3 (quadrature), the sequence {S1,S0} = 00→01→11→10→00 counts up and the reverse sequence counts down. A change of both bits at once is ignored.
- R5: The main filter sits in configuration bits [3:2] and the auxiliary filter in bits [5:4]. The codes are 0 = both directions, 1 = up events only, 2 = down events only, 3 = never count.
- R6: When the main counter counts up from top it goes to 0 and sets flag bit 0 (overflow). When it counts down from 0 it goes to top and sets flag bit 1 (underflow). The auxiliary counter wraps modulo 2^CNT_W and sets no flag.
- R7: Flag bit 2 is set by any decoded event whose direction differs from the direction of the previous decoded event. The direction before the first event counts as up.
- R8: A write to the counter (address 1) loads the main counter only in mode 1, and it wins over an event in the same cycle. In modes 0, 2 and 3 the write is ignored.
- R9: A write to the top buffer (address 3) can be read back at once. The active top (address 4) takes the buffer value 3 clock edges after the write edge, and a new buffer write restarts that delay.
- R10: A write to address 5 sets the flag bits written as 1, and a write to address 6 clears them; a clear wins over a set. Reads do not clear flags. Address 8 reads flags AND enable mask. irq is high one cycle after that AND is non-zero.
- R11: Writing 1 to bit 0 of address 9 sets both counters to 0 and the top to all ones, and cancels a pending top reload. It leaves the flags and the top buffer unchanged.
- R12: rd_data is registered. It shows the register selected by rd_addr as it stood before the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_in | input | 1 | Count input / quadrature phase A |
| s1_in | input | 1 | Direction input / quadrature phase B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | BUS_W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | BUS_W | Registered read data |
| irq | output | 1 | Registered interrupt, masked flags non-zero |

## Verification
The bench targets the wrap points. A counter that compares against the wrong bound would go past top, or would fail to land on top when it counts down from zero, and the overflow or underflow flag would then be missing. It drives an illegal double transition in quadrature mode: a decoder that takes it as a step would move the count by one. It times the top reload edge by edge, so an off-by-one in the delay shows up in the read value, and it checks that counter writes are ignored in the externally clocked modes and that the auxiliary counter wraps without flags. A behavioural model is compared with the read port and irq on every cycle, so any latency error in the synchronizer or the read register also fails.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int ADDR_W = 4;
  localparam int CFG_W  = 9;
  localparam int FLAG_W = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_OVS  = 2'd1,
    MODE_EXT1 = 2'd2,
    MODE_QUAD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    EV_BOTH = 2'd0,
    EV_UP   = 2'd1,
    EV_DOWN = 2'd2,
    EV_NONE = 2'd3
  } evsel_e;

  localparam logic [ADDR_W-1:0] A_CFG   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_AUX   = 4'd2;
  localparam logic [ADDR_W-1:0] A_TOPB  = 4'd3;
  localparam logic [ADDR_W-1:0] A_TOP   = 4'd4;
  localparam logic [ADDR_W-1:0] A_FSET  = 4'd5;
  localparam logic [ADDR_W-1:0] A_FCLR  = 4'd6;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd7;
  localparam logic [ADDR_W-1:0] A_FMSK  = 4'd8;
  localparam logic [ADDR_W-1:0] A_CMD   = 4'd9;

  localparam logic [CFG_W-1:0] CFG_RST = 9'h034;

  localparam int F_OVF = 0;
  localparam int F_UNF = 1;
  localparam int F_DIR = 2;
endpackage

// File: rtl/qpc_edge_decode.sv
module qpc_edge_decode
  import qpc_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  s0_in,
  input  logic  s1_in,
  input  mode_e mode,
  input  logic  fall_edge,
  input  logic  dir_from_s1,
  input  logic  dir_down,
  output logic  up_evt,
  output logic  dn_evt
);
  logic [SYNC-1:0] s0_sync, s1_sync;
  logic s0_prev, s1_prev;
  logic s0_cur, s1_cur;

  assign s0_cur = s0_sync[SYNC-1];
  assign s1_cur = s1_sync[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_sync <= '0;
      s1_sync <= '0;
      s0_prev <= 1'b0;
      s1_prev <= 1'b0;
    end else begin
      s0_sync <= {s0_sync[SYNC-2:0], s0_in};
      s1_sync <= {s1_sync[SYNC-2:0], s1_in};
      s0_prev <= s0_cur;
      s1_prev <= s1_cur;
    end
  end

  function automatic logic [1:0] phase_idx(input logic [1:0] ab);
    case (ab)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  logic [1:0] step;
  logic       edge_hit, single_dn;

  always_comb begin
    step      = phase_idx({s1_cur, s0_cur}) - phase_idx({s1_prev, s0_prev});
    edge_hit  = fall_edge ? (s0_prev & ~s0_cur) : (~s0_prev & s0_cur);
    single_dn = dir_from_s1 ? s1_cur : dir_down;
    up_evt    = 1'b0;
    dn_evt    = 1'b0;
    case (mode)
      MODE_OVS, MODE_EXT1: begin
        up_evt = edge_hit & ~single_dn;
        dn_evt = edge_hit &  single_dn;
      end
      MODE_QUAD: begin
        up_evt = (step == 2'd1);
        dn_evt = (step == 2'd3);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qpc_event_filter.sv
module qpc_event_filter
  import qpc_pkg::*;
(
  input  evsel_e sel,
  input  logic   up_evt,
  input  logic   dn_evt,
  output logic   inc,
  output logic   dec
);
  always_comb begin
    inc = up_evt & (sel == EV_BOTH || sel == EV_UP);
    dec = dn_evt & (sel == EV_BOTH || sel == EV_DOWN);
  end
endmodule

// File: rtl/qpc_top_reload.sv
module qpc_top_reload #(
  parameter int W     = 16,
  parameter int DELAY = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] data,
  output logic [W-1:0] topb_q,
  output logic [W-1:0] top_q
);
  localparam int PW = $clog2(DELAY + 1);
  localparam logic [PW-1:0] PEND_START = PW'(DELAY);

  logic [PW-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      topb_q <= '1;
      top_q  <= '1;
      pend_q <= '0;
    end else if (clear) begin
      top_q  <= '1;
      pend_q <= '0;
    end else if (load) begin
      topb_q <= data;
      pend_q <= PEND_START;
    end else if (pend_q != '0) begin
      if (pend_q == PW'(1)) top_q <= topb_q;
      pend_q <= pend_q - PW'(1);
    end
  end
endmodule

// File: rtl/qpc_core.sv
module qpc_core
  import qpc_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BUS_W      = 16,
  parameter int SYNC       = 2,
  parameter int RELOAD_DLY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s0_in,
  input  logic              s1_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              irq
);
  localparam int NCNT = 2;

  logic [CFG_W-1:0]  cfg_q;
  logic [CNT_W-1:0]  cnt_q, aux_q, top_q, topb_q;
  logic [FLAG_W-1:0] flags_q, ien_q, hw_flags, set_m, clr_m;
  logic              last_dn_q;
  mode_e             mode;
  logic              up_evt, dn_evt;
  evsel_e            fsel [NCNT];
  logic [NCNT-1:0]   inc, dec;

  assign mode    = mode_e'(cfg_q[1:0]);
  assign fsel[0] = evsel_e'(cfg_q[3:2]);
  assign fsel[1] = evsel_e'(cfg_q[5:4]);

  logic wr_cfg, wr_cnt, wr_topb, wr_fset, wr_fclr, wr_ien, cmd_rst, cnt_load;
  always_comb begin
    wr_cfg   = wr_en && wr_addr == A_CFG;
    wr_cnt   = wr_en && wr_addr == A_CNT;
    wr_topb  = wr_en && wr_addr == A_TOPB;
    wr_fset  = wr_en && wr_addr == A_FSET;
    wr_fclr  = wr_en && wr_addr == A_FCLR;
    wr_ien   = wr_en && wr_addr == A_IEN;
    cmd_rst  = wr_en && wr_addr == A_CMD && wr_data[0];
    cnt_load = wr_cnt && mode == MODE_OVS;
  end

  qpc_edge_decode #(.SYNC(SYNC)) dec_i (
    .clk(clk), .rst(rst), .s0_in(s0_in), .s1_in(s1_in), .mode(mode),
    .fall_edge(cfg_q[6]), .dir_from_s1(cfg_q[7]), .dir_down(cfg_q[8]),
    .up_evt(up_evt), .dn_evt(dn_evt)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_filt
    qpc_event_filter filt_i (
      .sel(fsel[g]), .up_evt(up_evt), .dn_evt(dn_evt),
      .inc(inc[g]), .dec(dec[g])
    );
  end

  qpc_top_reload #(.W(CNT_W), .DELAY(RELOAD_DLY)) top_i (
    .clk(clk), .rst(rst), .load(wr_topb), .clear(cmd_rst),
    .data(wr_data[CNT_W-1:0]), .topb_q(topb_q), .top_q(top_q)
  );

  // Hardware flag sources
  always_comb begin
    hw_flags        = '0;
    hw_flags[F_OVF] = inc[0] && cnt_q == top_q && !cmd_rst && !cnt_load;
    hw_flags[F_UNF] = dec[0] && cnt_q == '0    && !cmd_rst && !cnt_load;
    hw_flags[F_DIR] = (up_evt || dn_evt) && (dn_evt != last_dn_q);
    set_m           = wr_fset ? wr_data[FLAG_W-1:0] : '0;
    clr_m           = wr_fclr ? wr_data[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= CFG_RST;
      cnt_q     <= '0;
      aux_q     <= '0;
      flags_q   <= '0;
      ien_q     <= '0;
      last_dn_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= wr_data[CFG_W-1:0];
      if (wr_ien) ien_q <= wr_data[FLAG_W-1:0];
      if (up_evt || dn_evt) last_dn_q <= dn_evt;
      flags_q <= (flags_q | hw_flags | set_m) & ~clr_m;

      if (cmd_rst)       cnt_q <= '0;
      else if (cnt_load) cnt_q <= wr_data[CNT_W-1:0];
      else if (inc[0])   cnt_q <= (cnt_q == top_q) ? '0 : cnt_q + 1'b1;
      else if (dec[0])   cnt_q <= (cnt_q == '0) ? top_q : cnt_q - 1'b1;

      if (cmd_rst)     aux_q <= '0;
      else if (inc[1]) aux_q <= aux_q + 1'b1;
      else if (dec[1]) aux_q <= aux_q - 1'b1;
    end
  end

  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_CFG:  rd_mux[CFG_W-1:0]  = cfg_q;
      A_CNT:  rd_mux[CNT_W-1:0]  = cnt_q;
      A_AUX:  rd_mux[CNT_W-1:0]  = aux_q;
      A_TOPB: rd_mux[CNT_W-1:0]  = topb_q;
      A_TOP:  rd_mux[CNT_W-1:0]  = top_q;
      A_FSET: rd_mux[FLAG_W-1:0] = flags_q;
      A_IEN:  rd_mux[FLAG_W-1:0] = ien_q;
      A_FMSK: rd_mux[FLAG_W-1:0] = flags_q & ien_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_mux;
      irq     <= |(flags_q & ien_q);
    end
  end
endmodule

// File: rtl/qpc_core_chk.sv
module qpc_core_chk
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input mode_e             mode,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  aux_q,
  input logic [CNT_W-1:0]  top_q,
  input logic [CNT_W-1:0]  topb_q,
  input logic [FLAG_W-1:0] flags_q,
  input logic [FLAG_W-1:0] ien_q,
  input logic              irq
);
  // R2: disabled mode holds both counters when the bus is idle
  a_r2_off_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF && !wr_en) |=> ($stable(cnt_q) && $stable(aux_q)));

  // R6: a hardware overflow leaves the counter at zero
  a_r6_ovf_to_zero: assert property (@(posedge clk) disable iff (rst)
    ($rose(flags_q[F_OVF]) && !$past(wr_en)) |-> (cnt_q == '0));

  // R6: a hardware underflow leaves the counter at top
  a_r6_unf_to_top: assert property (@(posedge clk) disable iff (rst)
    ($rose(flags_q[F_UNF]) && !$past(wr_en)) |-> (cnt_q == $past(top_q)));

  // R9, R11: top only ever takes the buffer value or the all-ones reset value
  a_r9_top_source: assert property (@(posedge clk) disable iff (rst)
    (!$stable(top_q)) |-> (top_q == $past(topb_q) || top_q == '1));

  // R10: irq follows the masked flags one cycle later
  a_r10_irq_lag: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(flags_q & ien_q)));
endmodule

bind qpc_core qpc_core_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .mode(mode), .cnt_q(cnt_q),
  .aux_q(aux_q), .top_q(top_q), .topb_q(topb_q), .flags_q(flags_q),
  .ien_q(ien_q), .irq(irq)
);

// File: tb/qpc_core_tb.sv
module qpc_core_tb_top;
  localparam int W     = 16;
  localparam int BW    = 16;
  localparam int MASK  = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          s0_in = 1'b0, s1_in = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [BW-1:0] wr_data = '0;
  logic [3:0]    rd_addr = '0;
  logic [BW-1:0] rd_data;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  qpc_core #(.CNT_W(W), .BUS_W(BW)) dut_i (
    .clk(clk), .rst(rst), .s0_in(s0_in), .s1_in(s1_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_cfg, m_cnt, m_aux, m_top, m_topb, m_pend, m_flags, m_ien;
  int m_last_dn, m_rd, m_irq;
  int p0[3], p1[3];   // [0] first sync, [1] current, [2] previous

  function automatic int m_read(input int a);
    case (a)
      0: return m_cfg;
      1: return m_cnt;
      2: return m_aux;
      3: return m_topb;
      4: return m_top;
      5: return m_flags;
      7: return m_ien;
      8: return m_flags & m_ien;
      default: return 0;
    endcase
  endfunction

  function automatic int ph(input int b1, input int b0);
    case ({b1[0], b0[0]})
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 'h34; m_cnt = 0; m_aux = 0; m_top = MASK; m_topb = MASK;
      m_pend = 0; m_flags = 0; m_ien = 0; m_last_dn = 0; m_rd = 0; m_irq = 0;
      for (int i = 0; i < 3; i++) begin p0[i] = 0; p1[i] = 0; end
    end else begin
      int mode, up, dn, edg, d, ev, ainc, adec, minc, mdec, hw, cmd, dat;
      m_rd  = m_read(int'(rd_addr));
      m_irq = ((m_flags & m_ien) != 0);
      mode = m_cfg & 3; up = 0; dn = 0; dat = int'(wr_data);
      if (mode == 1 || mode == 2) begin
        edg = ((m_cfg >> 6) & 1) ? (p0[2] == 1 && p0[1] == 0) : (p0[2] == 0 && p0[1] == 1);
        d = ((m_cfg >> 7) & 1) ? p1[1] : ((m_cfg >> 8) & 1);
        if (edg) begin if (d != 0) dn = 1; else up = 1; end
      end else if (mode == 3) begin
        d = (ph(p1[1], p0[1]) - ph(p1[2], p0[2]) + 4) % 4;
        up = (d == 1); dn = (d == 3);
      end
      ev = (m_cfg >> 2) & 3;
      minc = up && (ev == 0 || ev == 1); mdec = dn && (ev == 0 || ev == 2);
      ev = (m_cfg >> 4) & 3;
      ainc = up && (ev == 0 || ev == 1); adec = dn && (ev == 0 || ev == 2);
      hw = 0;
      if (up || dn) begin
        if (dn != m_last_dn) hw |= 4;
        m_last_dn = dn;
      end
      cmd = wr_en && wr_addr == 9 && (dat & 1);
      if (cmd) m_cnt = 0;
      else if (wr_en && wr_addr == 1 && mode == 1) m_cnt = dat & MASK;
      else if (minc) begin
        if (m_cnt == m_top) begin m_cnt = 0; hw |= 1; end else m_cnt = (m_cnt + 1) & MASK;
      end else if (mdec) begin
        if (m_cnt == 0) begin m_cnt = m_top; hw |= 2; end else m_cnt = m_cnt - 1;
      end
      if (cmd) m_aux = 0;
      else if (ainc) m_aux = (m_aux + 1) & MASK;
      else if (adec) m_aux = (m_aux - 1) & MASK;
      if (cmd) begin m_top = MASK; m_pend = 0; end
      else if (wr_en && wr_addr == 3) begin m_topb = dat & MASK; m_pend = 3; end
      else if (m_pend != 0) begin
        if (m_pend == 1) m_top = m_topb;
        m_pend--;
      end
      m_flags = (m_flags | hw | ((wr_en && wr_addr == 5) ? (dat & 7) : 0))
                & ~((wr_en && wr_addr == 6) ? (dat & 7) : 0);
      if (wr_en && wr_addr == 7) m_ien = dat & 7;
      if (wr_en && wr_addr == 0) m_cfg = dat & 'h1FF;
      p0[2] = p0[1]; p0[1] = p0[0]; p0[0] = int'(s0_in);
      p1[2] = p1[1]; p1[1] = p1[0]; p1[0] = int'(s1_in);
    end
  end

  // per-cycle comparison against the model (R12 read path, R10 irq)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rd_data !== BW'(m_rd)) begin
        errors++;
        $display("FAIL R12 model read addr %0d: actual %0h expected %0h", rd_addr, rd_data, m_rd);
      end
      checks++;
      if (irq !== m_irq[0]) begin
        errors++;
        $display("FAIL R10 model irq: actual %0b expected %0b", irq, m_irq[0]);
      end
    end
  end

  // ---------------- directed tasks ----------------
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = BW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 4'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic pulse();
    s0_in = 1'b1; repeat (4) @(negedge clk);
    s0_in = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic quad(input int ab);
    s1_in = ab[1]; s0_in = ab[0];
    repeat (4) @(negedge clk);
  endtask

  int v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 cfg", v, 'h34);
    rd(1, v); chk("R1 cnt", v, 0);
    rd(2, v); chk("R1 aux", v, 0);
    rd(4, v); chk("R1 top", v, MASK);
    rd(3, v); chk("R1 topb", v, MASK);
    rd(5, v); chk("R1 flags", v, 0);
    chk("R1 irq", int'(irq), 0);
    // R2 disabled
    pulse(); pulse();
    rd(1, v); chk("R2 cnt off", v, 0);
    // R3/R5 single input, rising, up; main both, aux up-only
    wr(0, 'h11);
    repeat (5) pulse();
    rd(1, v); chk("R3 cnt up", v, 5);
    rd(2, v); chk("R5 aux up", v, 5);
    // R3 direction bit down; aux up-only ignores
    wr(0, 'h111);
    repeat (2) pulse();
    rd(1, v); chk("R3 cnt down", v, 3);
    rd(2, v); chk("R5 aux ignores down", v, 5);
    // R3 falling edge, direction from S1
    wr(0, 'hD1);
    pulse();
    rd(1, v); chk("R3 falling up", v, 4);
    s1_in = 1'b1; repeat (4) @(negedge clk);
    pulse();
    rd(1, v); chk("R3 s1 down", v, 3);
    rd(2, v); chk("R5 aux after s1", v, 6);
    s1_in = 1'b0; repeat (4) @(negedge clk);
    // R9 buffered top reload timing
    rd_addr = 4'd4;
    wr(3, 5);
    repeat (3) @(negedge clk);
    chk("R9 top still old", int'(rd_data), MASK);
    @(negedge clk);
    chk("R9 top loaded", int'(rd_data), 5);
    rd(3, v); chk("R9 topb readback", v, 5);
    // R6/R7 wrap and flags
    wr(6, 7);
    wr(0, 'h11);
    repeat (3) pulse();
    rd(1, v); chk("R6 overflow wrap", v, 0);
    rd(5, v); chk("R6 R7 flags ovf+dir", v, 5);
    wr(0, 'h111);
    repeat (2) pulse();
    rd(1, v); chk("R6 underflow wrap", v, 4);
    rd(5, v); chk("R6 flags unf", v, 7);
    rd(2, v); chk("R5 aux", v, 9);
    // R8 counter write by mode
    wr(1, 2);
    rd(1, v); chk("R8 write ovs", v, 2);
    wr(0, 'h12); wr(1, 9);
    rd(1, v); chk("R8 ignored ext single", v, 2);
    wr(0, 'h13); wr(1, 9);
    rd(1, v); chk("R8 ignored quad", v, 2);
    // R4 quadrature, aux none
    wr(0, 'h33);
    quad(1); quad(3); quad(2); quad(0);
    rd(1, v); chk("R4 quad up wrap", v, 0);
    quad(2);
    rd(1, v); chk("R4 quad down wrap", v, 5);
    quad(1);
    rd(1, v); chk("R4 illegal ignored", v, 5);
    quad(0);
    rd(1, v); chk("R4 quad down", v, 4);
    rd(2, v); chk("R5 aux none", v, 9);
    // R10 flag set/clear/mask/irq
    wr(6, 7);
    rd(5, v); chk("R10 cleared", v, 0);
    wr(7, 2);
    chk("R10 irq low", int'(irq), 0);
    wr(5, 2);
    rd(8, v); chk("R10 masked", v, 2);
    chk("R10 irq high", int'(irq), 1);
    rd(5, v); chk("R10 read no clear", v, 2);
    wr(5, 1);
    rd(5, v); chk("R10 set", v, 3);
    rd(8, v); chk("R10 masked2", v, 2);
    wr(6, 2);
    rd(8, v); chk("R10 masked zero", v, 0);
    chk("R10 irq drop", int'(irq), 0);
    // R11 counter reset command
    wr(9, 1);
    rd(1, v); chk("R11 cnt", v, 0);
    rd(2, v); chk("R11 aux", v, 0);
    rd(4, v); chk("R11 top", v, MASK);
    rd(3, v); chk("R11 topb kept", v, 5);
    rd(5, v); chk("R11 flags kept", v, 1);
    // R6 aux wraps with no flag; main filter none
    wr(0, 'h12D);
    pulse();
    rd(2, v); chk("R6 aux wrap", v, MASK);
    rd(1, v); chk("R5 main none", v, 0);
    rd(5, v); chk("R6 no aux flag", v, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule